// File: doc/BRIEF.md
# I2C Master Command and Data FIFO Front End

This block sits between a register bus and the byte engine of an I2C master. Software writes 9-bit command words to one data/command register. A word with bit 8 clear carries a byte to send. A word with bit 8 set asks the engine to fetch one byte. Commands wait in a transmit FIFO. Fetched bytes collect in a receive FIFO, and software pops them by reading the same register. Software can read the fill level of each FIFO, a fixed word that reports both depths, two programmable thresholds and an enable bit.

The block drives two level conditions for the interrupt logic. Transmit-empty holds while few enough commands remain queued. Receive-full holds while enough bytes are waiting. A read command is accepted only if a receive slot can be reserved for its byte, so the receive FIFO can never overflow. A transfer abort from the bus side empties both FIFOs, and so does clearing the enable bit.

A stub stands in for the bus engine. On each cycle that `bus_ready` is high, it takes one command from the transmit FIFO. A byte command is shown on `bus_wr_valid`/`bus_wr_byte`. A read command returns the byte `RD_SEED + n`, where n counts the reads served since reset.

Top module: `iic_cmd_front`

## Requirements
- R1: After reset the block is disabled, both fill levels and both thresholds read 0, transmit-empty is 1 and receive-full is 0. Register word indices on `reg_addr`:
  - 0: control, with the enable in bit 0
  - 1: data/command
  - 2: transmit level
  - 3: receive level
  - 4: transmit threshold
  - 5: receive threshold
  - 6: parameter word
  - Index 7 reads 0.
- R2: The parameter word returns transmit depth minus one in bits 23:16 and receive depth minus one in bits 15:8. All other bits are 0, so the defaults give 0x00070700.
- R3: While enabled, a data/command write with bit 8 clear queues bits 7:0. The stub presents the queued bytes on `bus_wr_byte` in the order they were written, one per ready cycle.
- R4: A data/command write with bit 8 set queues a read request. Its byte, `RD_SEED` (0xC0) plus the number of reads served since reset, is popped in order by reading the data/command register.
- R5: The level registers report the current entry counts. A push and a pop on the same FIFO in the same cycle leave its level unchanged, and the pop returns the older entry.
- R6: `tx_empty_lvl` is 1 exactly while the transmit level is at or below the transmit threshold.
- R7: `rx_full_lvl` is 1 exactly while the receive level is above the receive threshold. A threshold of 0 flags a single buffered byte.
- R8: A data/command write while the transmit FIFO is full is dropped and pulses `tx_overflow` for one cycle, one cycle after the write.
- R9: A data/command read while the receive FIFO is empty returns 0 and pulses `rx_underflow` for one cycle, one cycle after the read.
- R10: A read request is dropped and pulses `tx_overflow` when the receive level plus the read requests still queued already equals the receive depth. This applies even if the transmit FIFO has room. A byte command in the same state is still accepted.
- R11: A cycle with `bus_abort` high empties both FIFOs and discards any queued read requests.
- R12: While disabled, both FIFOs are held empty. Data/command writes are ignored and raise no overflow event.
- R13: A threshold write above depth minus one stores depth minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data/command index) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` and current state |
| bus_ready | input | 1 | Stub may consume one command this cycle |
| bus_abort | input | 1 | Transfer abort, flushes both FIFOs |
| bus_wr_valid | output | 1 | Stub sends a byte this cycle |
| bus_wr_byte | output | 8 | Byte being sent |
| bus_rd_valid | output | 1 | Stub serves a read request this cycle |
| tx_empty_lvl | output | 1 | Transmit level at or below its threshold |
| rx_full_lvl | output | 1 | Receive level above its threshold |
| tx_overflow | output | 1 | One-cycle pulse for a dropped command |
| rx_underflow | output | 1 | One-cycle pulse for a read of an empty receive FIFO |

## Verification
The transmit FIFO can take a software push and a stub pop in the same cycle. The receive FIFO can take a stub push and a software pop in the same cycle. The bench forces the first case by raising `bus_ready` in the same cycle as a data/command write, with bytes already queued. It expects the level to stay put and the oldest byte to appear on the bus. It forces the second case by holding a read request in the transmit FIFO, with one byte already received, and then raising `bus_ready` and the data/command read together. It expects the older byte on `reg_rdata`, then an unchanged receive level, then the newer byte on the next read.

// File: rtl/iic_front_pkg.sv
// Package: shared register indices and command word layout for the I2C
// master FIFO front end. Assumes a 32-bit register bus with word indices.
package iic_front_pkg;
    localparam int REG_ADDR_W = 3;
    localparam int REG_DATA_W = 32;
    localparam int CMD_W      = 9;

    typedef enum logic [REG_ADDR_W-1:0] {
        IDX_CTRL   = 3'd0,
        IDX_DATA   = 3'd1,
        IDX_TX_LVL = 3'd2,
        IDX_RX_LVL = 3'd3,
        IDX_TX_THR = 3'd4,
        IDX_RX_THR = 3'd5,
        IDX_PARAM  = 3'd6,
        IDX_SPARE  = 3'd7
    } reg_idx_e;

    // Bit 8 selects a read request, bits 7:0 carry the byte to send.
    typedef struct packed {
        logic       rd;
        logic [7:0] data;
    } cmd_t;
endpackage

// File: rtl/iic_sync_fifo.sv
// Module: single-clock FIFO with a level counter and a flush that wins
// over push and pop. Assumes the caller never pushes when full or pops
// when empty; both are also gated inside. Head entry is shown
// combinationally on rdata.
module iic_sync_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign rdata   = mem[rd_ptr];

    // Storage write, no reset needed for data.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and level bookkeeping with flush priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R8
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> !full);
    // R11
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty && !flush) |=> $stable(level));
endmodule

// File: rtl/iic_thresh_reg.sv
// Module: one programmable level threshold plus its level flag. Writes
// above DEPTH-1 are clamped. ABOVE selects the flag sense: 1 gives
// level > thr, 0 gives level <= thr.
module iic_thresh_reg #(
    parameter int DEPTH = 8,
    parameter bit ABOVE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic [$clog2(DEPTH+1)-1:0] level,
    output logic [$clog2(DEPTH+1)-1:0] thr,
    output logic        flag
);
    localparam int LW   = $clog2(DEPTH+1);
    localparam int MAXV = DEPTH - 1;

    // Threshold storage with clamp to the highest meaningful value.
    always_ff @(posedge clk) begin
        if (!rst_n)                   thr <= '0;
        else if (wr_en) begin
            if (wdata > 32'(MAXV))    thr <= LW'(MAXV);
            else                      thr <= wdata[LW-1:0];
        end
    end

    generate
        if (ABOVE) begin : g_above
            assign flag = (level > thr);
        end else begin : g_at_or_below
            assign flag = (level <= thr);
        end
    endgenerate

    // R13
    thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr <= LW'(MAXV));
endmodule

// File: rtl/iic_bus_stub.sv
// Module: stand-in for the bus byte engine. Consumes one command per
// ready cycle while enabled and not aborting. Byte commands are shown
// on the wr outputs. Read commands return RD_SEED plus a served count.
module iic_bus_stub
    import iic_front_pkg::*;
#(
    parameter logic [7:0] RD_SEED = 8'hC0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready,
    input  logic       enable,
    input  logic       abort,
    input  logic       cmd_valid,
    input  cmd_t       cmd,
    output logic       cmd_pop,
    output logic       wr_valid,
    output logic [7:0] wr_byte,
    output logic       rd_push,
    output logic [7:0] rd_byte
);
    logic [7:0] served;

    assign cmd_pop  = ready & enable & ~abort & cmd_valid;
    assign wr_valid = cmd_pop & ~cmd.rd;
    assign wr_byte  = cmd.data;
    assign rd_push  = cmd_pop & cmd.rd;
    assign rd_byte  = RD_SEED + served;

    // Count of read requests served since reset, not cleared by flush.
    always_ff @(posedge clk) begin
        if (!rst_n)       served <= '0;
        else if (rd_push) served <= served + 1'b1;
    end
endmodule

// File: rtl/iic_cmd_front.sv
// Module: register-side FIFO front end of an I2C master. Decodes a small
// register map, queues 9-bit commands, reserves receive slots for read
// requests and raises level flags and error pulses. Assumes one register
// access per cycle and that bus_abort comes from the bus side.
module iic_cmd_front
    import iic_front_pkg::*;
#(
    parameter int         TX_DEPTH = 8,
    parameter int         RX_DEPTH = 8,
    parameter logic [7:0] RD_SEED  = 8'hC0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        bus_ready,
    input  logic        bus_abort,
    output logic        bus_wr_valid,
    output logic [7:0]  bus_wr_byte,
    output logic        bus_rd_valid,
    output logic        tx_empty_lvl,
    output logic        rx_full_lvl,
    output logic        tx_overflow,
    output logic        rx_underflow
);
    localparam int TXL_W = $clog2(TX_DEPTH+1);
    localparam int RXL_W = $clog2(RX_DEPTH+1);
    localparam logic [7:0] TX_DM1 = 8'(TX_DEPTH-1);
    localparam logic [7:0] RX_DM1 = 8'(RX_DEPTH-1);

    logic             en_q, flush;
    logic             data_wr, data_rd, slot_free, tx_push, cmd_drop, rx_pop;
    cmd_t             cmd_in, tx_head;
    logic [TXL_W-1:0] tx_level, tx_thr, pend_rd;
    logic [RXL_W-1:0] rx_level, rx_thr;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             stub_pop, stub_rd_push;
    logic [7:0]       stub_rd_byte, rx_head;

    assign data_wr   = reg_wr && (reg_addr == IDX_DATA);
    assign data_rd   = reg_rd && (reg_addr == IDX_DATA);
    assign flush     = bus_abort | ~en_q;
    assign cmd_in    = cmd_t'(reg_wdata[CMD_W-1:0]);
    assign slot_free = (16'(rx_level) + 16'(pend_rd)) < 16'(RX_DEPTH);
    assign tx_push   = data_wr & en_q & ~bus_abort & ~tx_full & (~cmd_in.rd | slot_free);
    assign cmd_drop  = data_wr & en_q & ~bus_abort & ~tx_push;
    assign rx_pop    = data_rd & ~rx_empty;

    // Enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 en_q <= 1'b0;
        else if (reg_wr && reg_addr == IDX_CTRL)    en_q <= reg_wdata[0];
    end

    // Read requests queued but not yet served, used for slot reservation.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) pend_rd <= '0;
        else pend_rd <= pend_rd + TXL_W'(tx_push & cmd_in.rd) - TXL_W'(stub_rd_push);
    end

    // One-cycle error pulses, registered after the offending access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_overflow  <= 1'b0;
            rx_underflow <= 1'b0;
        end else begin
            tx_overflow  <= cmd_drop;
            rx_underflow <= data_rd & rx_empty;
        end
    end

    iic_sync_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(tx_push), .wdata(cmd_in), .pop(stub_pop), .rdata(tx_head),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    iic_sync_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(stub_rd_push), .wdata(stub_rd_byte), .pop(rx_pop), .rdata(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    iic_thresh_reg #(.DEPTH(TX_DEPTH), .ABOVE(1'b0)) u_tx_thr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && reg_addr == IDX_TX_THR), .wdata(reg_wdata),
        .level(tx_level), .thr(tx_thr), .flag(tx_empty_lvl)
    );

    iic_thresh_reg #(.DEPTH(RX_DEPTH), .ABOVE(1'b1)) u_rx_thr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && reg_addr == IDX_RX_THR), .wdata(reg_wdata),
        .level(rx_level), .thr(rx_thr), .flag(rx_full_lvl)
    );

    iic_bus_stub #(.RD_SEED(RD_SEED)) u_stub (
        .clk(clk), .rst_n(rst_n), .ready(bus_ready), .enable(en_q),
        .abort(bus_abort), .cmd_valid(~tx_empty), .cmd(tx_head),
        .cmd_pop(stub_pop), .wr_valid(bus_wr_valid), .wr_byte(bus_wr_byte),
        .rd_push(stub_rd_push), .rd_byte(stub_rd_byte)
    );

    assign bus_rd_valid = stub_rd_push;

    // Register read multiplexer; an empty receive FIFO reads as zero.
    always_comb begin
        case (reg_idx_e'(reg_addr))
            IDX_CTRL:   reg_rdata = {31'b0, en_q};
            IDX_DATA:   reg_rdata = rx_empty ? 32'b0 : {24'b0, rx_head};
            IDX_TX_LVL: reg_rdata = 32'(tx_level);
            IDX_RX_LVL: reg_rdata = 32'(rx_level);
            IDX_TX_THR: reg_rdata = 32'(tx_thr);
            IDX_RX_THR: reg_rdata = 32'(rx_thr);
            IDX_PARAM:  reg_rdata = {8'b0, TX_DM1, RX_DM1, 8'b0};
            default:    reg_rdata = 32'b0;
        endcase
    end

    // R10
    rx_reserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (16'(rx_level) + 16'(pend_rd)) <= 16'(RX_DEPTH));
    // R10
    rx_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stub_rd_push |-> !rx_full);
    // R9
    underflow_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == IDX_DATA && rx_level == '0) |=> rx_underflow);
    // R12
    off_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (tx_level == '0 && rx_level == '0));
    // R12
    off_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !tx_overflow);
endmodule

// File: tb/tb_iic_cmd_front.sv
`timescale 1ns/1ps
module tb_iic_cmd_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_ready = 1'b0, bus_abort = 1'b0;
    logic        bus_wr_valid, bus_rd_valid;
    logic [7:0]  bus_wr_byte;
    logic        tx_empty_lvl, rx_full_lvl, tx_overflow, rx_underflow;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_rd   = 0;
    int wr_n     = 0;
    logic [7:0] wr_log [64];
    logic       last_ovf, last_unf;
    logic       timed_out = 1'b0;

    always #2 clk = ~clk;

    iic_cmd_front dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_ready(bus_ready), .bus_abort(bus_abort),
        .bus_wr_valid(bus_wr_valid), .bus_wr_byte(bus_wr_byte),
        .bus_rd_valid(bus_rd_valid), .tx_empty_lvl(tx_empty_lvl),
        .rx_full_lvl(rx_full_lvl), .tx_overflow(tx_overflow),
        .rx_underflow(rx_underflow)
    );

    // Records every byte the stub sends, sampled mid-cycle.
    always begin
        @(negedge clk); #1;
        if (bus_wr_valid && wr_n < 64) begin
            wr_log[wr_n] = bus_wr_byte;
            wr_n++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        last_ovf = tx_overflow;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        last_unf = rx_underflow;
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        reg_read(a, v);
        chk(tag, v, exp);
    endtask

    task automatic run_ready(input int n);
        @(negedge clk); bus_ready = 1'b1;
        repeat (n) @(negedge clk);
        bus_ready = 1'b0;
    endtask

    task automatic t_reset;
        chk_reg("R1 tx level", 3'd2, 0);
        chk_reg("R1 rx level", 3'd3, 0);
        chk_reg("R1 ctrl", 3'd0, 0);
        chk_reg("R1 tx thr", 3'd4, 0);
        chk_reg("R1 rx thr", 3'd5, 0);
        chk_reg("R1 spare", 3'd7, 0);
        chk_reg("R2 param", 3'd6, 32'h0007_0700);
        chk("R6 reset tx_empty_lvl", tx_empty_lvl, 1);
        chk("R7 reset rx_full_lvl", rx_full_lvl, 0);
    endtask

    task automatic t_disabled_write;
        reg_write(3'd1, 32'h55);
        chk("R12 no ovf while off", last_ovf, 0);
        chk_reg("R12 tx level while off", 3'd2, 0);
        reg_write(3'd0, 1);
        chk_reg("R1 ctrl enabled", 3'd0, 1);
    endtask

    task automatic t_writes;
        int base;
        reg_write(3'd1, 32'h11);
        reg_write(3'd1, 32'h22);
        reg_write(3'd1, 32'h33);
        chk_reg("R5 tx level 3", 3'd2, 3);
        chk("R6 tx_empty_lvl above thr", tx_empty_lvl, 0);
        reg_write(3'd4, 3);
        chk("R6 tx_empty_lvl at thr", tx_empty_lvl, 1);
        reg_write(3'd4, 2);
        chk("R6 tx_empty_lvl thr 2", tx_empty_lvl, 0);
        base = wr_n;
        run_ready(5);
        chk("R3 sent count", wr_n - base, 3);
        chk("R3 byte 0", wr_log[base], 8'h11);
        chk("R3 byte 1", wr_log[base+1], 8'h22);
        chk("R3 byte 2", wr_log[base+2], 8'h33);
        chk_reg("R5 tx level drained", 3'd2, 0);
        chk("R6 tx_empty_lvl drained", tx_empty_lvl, 1);
    endtask

    task automatic t_reads;
        int base;
        base = wr_n;
        reg_write(3'd1, 32'h100);
        reg_write(3'd1, 32'h100);
        chk_reg("R4 tx holds reads", 3'd2, 2);
        chk_reg("R4 rx empty before", 3'd3, 0);
        run_ready(4);
        chk_reg("R5 rx level 2", 3'd3, 2);
        chk("R7 rx_full_lvl thr 0", rx_full_lvl, 1);
        chk("R4 no bytes sent", wr_n - base, 0);
        chk_reg("R4 first read", 3'd1, 8'hC0 + exp_rd);
        chk_reg("R4 second read", 3'd1, 8'hC0 + exp_rd + 1);
        exp_rd += 2;
        chk_reg("R5 rx level 0", 3'd3, 0);
        chk("R7 rx_full_lvl empty", rx_full_lvl, 0);
    endtask

    task automatic t_overflow;
        int base;
        for (int i = 0; i < 8; i++) begin
            reg_write(3'd1, 32'h80 + i);
            chk("R8 no ovf below full", last_ovf, 0);
        end
        reg_write(3'd1, 32'hEE);
        chk("R8 ovf pulse when full", last_ovf, 1);
        @(negedge clk);
        chk("R8 ovf pulse one cycle", tx_overflow, 0);
        chk_reg("R8 level stays full", 3'd2, 8);
        base = wr_n;
        run_ready(10);
        chk("R8 eight sent", wr_n - base, 8);
        chk("R8 first kept", wr_log[base], 8'h80);
        chk("R8 last kept", wr_log[base+7], 8'h87);
    endtask

    task automatic t_underflow;
        chk_reg("R9 empty read zero", 3'd1, 0);
        chk("R9 underflow pulse", last_unf, 1);
        chk_reg("R9 rx level", 3'd3, 0);
        chk("R9 pulse gone", rx_underflow, 0);
    endtask

    task automatic t_rx_thresh;
        reg_write(3'd5, 100);
        chk_reg("R13 rx thr clamped", 3'd5, 7);
        reg_write(3'd4, 40);
        chk_reg("R13 tx thr clamped", 3'd4, 7);
        reg_write(3'd5, 1);
        bus_ready = 1'b1;
        reg_write(3'd1, 32'h100);
        chk_reg("R7 rx level 1", 3'd3, 1);
        chk("R7 rx_full_lvl at thr", rx_full_lvl, 0);
        reg_write(3'd1, 32'h100);
        @(negedge clk);
        bus_ready = 1'b0;
        chk_reg("R7 rx level 2", 3'd3, 2);
        chk("R7 rx_full_lvl above thr", rx_full_lvl, 1);
        chk_reg("R4 read c2", 3'd1, 8'hC0 + exp_rd);
        chk_reg("R4 read c3", 3'd1, 8'hC0 + exp_rd + 1);
        exp_rd += 2;
        reg_write(3'd5, 0);
    endtask

    task automatic t_reserve_abort;
        bus_ready = 1'b1;
        for (int i = 0; i < 6; i++) reg_write(3'd1, 32'h100);
        repeat (2) @(negedge clk);
        bus_ready = 1'b0;
        exp_rd += 6;
        chk_reg("R10 rx level 6", 3'd3, 6);
        reg_write(3'd1, 32'h100);
        chk("R10 7th slot ok", last_ovf, 0);
        reg_write(3'd1, 32'h100);
        chk("R10 8th slot ok", last_ovf, 0);
        reg_write(3'd1, 32'h100);
        chk("R10 no slot drops", last_ovf, 1);
        chk_reg("R10 tx level 2", 3'd2, 2);
        reg_write(3'd1, 32'h44);
        chk("R10 byte still accepted", last_ovf, 0);
        chk_reg("R10 tx level 3", 3'd2, 3);
        @(negedge clk); bus_abort = 1'b1;
        @(negedge clk); bus_abort = 1'b0;
        chk_reg("R11 tx flushed", 3'd2, 0);
        chk_reg("R11 rx flushed", 3'd3, 0);
        chk("R11 rx_full_lvl cleared", rx_full_lvl, 0);
    endtask

    task automatic t_disable_flush;
        bus_ready = 1'b1;
        reg_write(3'd1, 32'h100);
        repeat (2) @(negedge clk);
        bus_ready = 1'b0;
        exp_rd += 1;
        reg_write(3'd1, 32'h66);
        chk_reg("R12 tx before off", 3'd2, 1);
        chk_reg("R12 rx before off", 3'd3, 1);
        reg_write(3'd0, 0);
        chk_reg("R12 tx flushed off", 3'd2, 0);
        chk_reg("R12 rx flushed off", 3'd3, 0);
        reg_write(3'd1, 32'h77);
        chk("R12 ignored no ovf", last_ovf, 0);
        reg_write(3'd0, 1);
        chk_reg("R12 still empty after on", 3'd2, 0);
    endtask

    task automatic t_same_cycle;
        int base;
        logic [31:0] v;
        reg_write(3'd1, 32'hA1);
        reg_write(3'd1, 32'hA2);
        reg_write(3'd1, 32'hA3);
        base = wr_n;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'hA4; bus_ready = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; bus_ready = 1'b0;
        chk_reg("R5 tx push+pop level", 3'd2, 3);
        chk("R5 oldest sent", wr_log[base], 8'hA1);
        run_ready(5);
        chk("R5 all sent", wr_n - base, 4);
        chk("R5 new byte last", wr_log[base+3], 8'hA4);
        bus_ready = 1'b1;
        reg_write(3'd1, 32'h100);
        repeat (2) @(negedge clk);
        bus_ready = 1'b0;
        reg_write(3'd1, 32'h100);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'd1; bus_ready = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; bus_ready = 1'b0;
        chk("R5 rx pop returns older", v, 8'hC0 + exp_rd);
        chk_reg("R5 rx push+pop level", 3'd3, 1);
        chk_reg("R5 rx newer byte", 3'd1, 8'hC0 + exp_rd + 1);
        exp_rd += 2;
        chk_reg("R5 tx read served", 3'd2, 0);
    endtask

    task automatic run_all;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled_write();
        t_writes();
        t_reads();
        t_overflow();
        t_underflow();
        t_rx_thresh();
        t_reserve_abort();
        t_disable_flush();
        t_same_cycle();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule